// File: doc/BRIEF.md
# Four-Slot Pulse Position Modulator

This block turns a stream of bytes into a serial light-pulse line for a 4 Mbps infrared link. A byte is cut into 2-bit groups. Each group goes out as a chip of four time slots that carries exactly one pulse, and the pulse's slot gives the group's value. The group made of bits 1:0 goes first and bits 7:6 go last. The two bits of a group keep their order and are used directly as the slot number. A byte therefore fills four chips, which is 16 slots or 2 µs at the 8 MHz slot rate.

A clock-enable pulse `slot_en` sets the slot timing, and the block moves forward by one slot on each clock edge where that pulse is high. Bytes arrive on a valid/ready handshake. The byte is transferred on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high only on an enabled edge, and only while the block is idle or is sending the final slot of the final chip of the current byte. This back-pressure lets a waiting byte follow the current one with no gap slots. A source may hold `in_valid` high and its data steady for as long as it wants. While `in_ready` is low the byte stays at the source and has no effect on the line. When no byte is waiting at a byte boundary, the line goes low and stays low.

Top module: `ppm_modulator`

## Requirements
- R1: The slot position advances only on clock edges with `slot_en` high, and `ppm_out` does not change between such edges except through reset.
- R2: Each chip of four enabled slots carries exactly one high slot. Group value 00 puts the pulse in slot 1, 01 in slot 2, 10 in slot 3 and 11 in slot 4, where slot 1 is the first slot in time.
- R3: The groups of a byte are sent from bits 1:0 first, then bits 3:2, then 5:4, and bits 7:6 last. Inside a group, bit 1 of the pair is the high bit of the slot number.
- R4: An accepted byte takes exactly 16 enabled slots. A byte accepted at the end of the previous byte starts on the very next enabled slot, with no gap.
- R5: `in_ready` is high only on a cycle with `slot_en` high while the block is idle or is showing the fourth slot of the fourth chip. A byte offered at any other time is not taken and does not disturb the line.
- R6: If no byte is accepted at a byte boundary, `ppm_out` is low from the next enabled slot on until a byte is accepted. A new byte always starts at slot 1 of its first chip, so no partial chip appears.
- R7: Synchronous active-high `rst` forces the idle state with `ppm_out` low and drops any byte in progress. The next accepted byte is sent whole and correct.
- R8: Byte 8'b10110001 gives pulses in slots 2, 1, 4 and 3 of its four successive chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_en | input | 1 | One-cycle enable per slot time (8 MHz rate) |
| in_valid | input | 1 | Byte offered by the source |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Block takes the byte on this edge when valid |
| ppm_out | output | 1 | Serial pulse line, high during a pulse slot |

## Verification
The bench builds the block with its default parameters: 8-bit words and 2-bit groups, which gives four chips of four slots. The slot enable comes from the bench and is switched between every cycle, every third cycle and every fifth cycle. With the slower settings the bench can check that the line holds still between enables and that the handshake waits for the enable. Back-to-back streams, idle gaps and a reset in the middle of a byte cover the byte-boundary rules, and the 8'b10110001 sample confirms the group order.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  // Line state of the modulator.
  typedef enum logic {
    PPM_IDLE = 1'b0,
    PPM_SEND = 1'b1
  } ppm_state_e;

  // Index width that never collapses to zero bits.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ppm_chip_timer.sv
module ppm_chip_timer #(
  parameter int SLOTS = 4,
  parameter int GROUPS = 4,
  parameter int SLOT_IW = 2,
  parameter int GRP_IW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               advance,
  output logic [SLOT_IW-1:0] slot_idx,
  output logic [GRP_IW-1:0]  grp_idx,
  output logic               chip_last,
  output logic               word_last
);

  localparam logic [SLOT_IW-1:0] SLOT_END = SLOT_IW'(SLOTS - 1);
  localparam logic [GRP_IW-1:0]  GRP_END  = GRP_IW'(GROUPS - 1);

  assign chip_last = (slot_idx == SLOT_END);
  assign word_last = chip_last && (grp_idx == GRP_END);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      slot_idx <= '0;
      grp_idx  <= '0;
    end else if (advance) begin
      if (chip_last) begin
        slot_idx <= '0;
        grp_idx  <= word_last ? '0 : grp_idx + 1'b1;
      end else begin
        slot_idx <= slot_idx + 1'b1;
      end
    end
  end

  // R3: after the last slot of a chip the next group follows in order
  a_r3_group_step: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && chip_last && !word_last) |=> (grp_idx == $past(grp_idx) + 1'b1));

  // R1: position frozen without an advance or load
  a_r1_hold_position: assert property (@(posedge clk) disable iff (rst)
    (!advance && !load) |=> ($stable(slot_idx) && $stable(grp_idx)));

endmodule

// File: rtl/ppm_word_reg.sv
module ppm_word_reg #(
  parameter int DATA_W = 8,
  parameter int SYM_W = 2,
  parameter int GROUPS = 4,
  parameter int GRP_IW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic [GRP_IW-1:0] grp_idx,
  output logic [SYM_W-1:0]  symbol
);

  logic [DATA_W-1:0] word_q;
  logic [SYM_W-1:0]  groups [GROUPS];

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (load) word_q <= din;
  end

  // Group k is bits [k*SYM_W +: SYM_W]; index 0 leaves first.
  for (genvar k = 0; k < GROUPS; k++) begin : g_split
    assign groups[k] = word_q[k*SYM_W +: SYM_W];
  end

  assign symbol = groups[grp_idx];

  // R5: held word changes only on a load
  a_r5_word_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word_q));

endmodule

// File: rtl/ppm_slot_decode.sv
module ppm_slot_decode #(
  parameter int SYM_W = 2,
  parameter int SLOTS = 4,
  parameter int SLOT_IW = 2
) (
  input  logic               active,
  input  logic [SYM_W-1:0]   symbol,
  input  logic [SLOT_IW-1:0] slot_idx,
  output logic               pulse
);

  logic [SLOTS-1:0] slot_hot;

  for (genvar k = 0; k < SLOTS; k++) begin : g_hot
    assign slot_hot[k] = (symbol == SYM_W'(k));
  end

  assign pulse = active && slot_hot[slot_idx];

  always_comb begin
    // R2: exactly one candidate slot per symbol
    a_r2_single_slot: assert ($onehot(slot_hot));
  end

endmodule

// File: rtl/ppm_modulator.sv
module ppm_modulator #(
  parameter int DATA_W = 8,
  parameter int SYM_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              ppm_out
);
  import ppm_pkg::*;

  localparam int SLOTS   = 1 << SYM_W;
  localparam int GROUPS  = DATA_W / SYM_W;
  localparam int SLOT_IW = SYM_W;
  localparam int GRP_IW  = idx_w(GROUPS);

  ppm_state_e         state_q;
  logic               take;
  logic [SLOT_IW-1:0] slot_idx;
  logic [GRP_IW-1:0]  grp_idx;
  logic               chip_last;
  logic               word_last;
  logic [SYM_W-1:0]   symbol;
  logic               sending;

  assign sending  = (state_q == PPM_SEND);
  assign in_ready = slot_en && (!sending || word_last);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) state_q <= PPM_IDLE;
    else if (slot_en && (!sending || word_last))
      state_q <= in_valid ? PPM_SEND : PPM_IDLE;
  end

  ppm_chip_timer #(
    .SLOTS(SLOTS), .GROUPS(GROUPS), .SLOT_IW(SLOT_IW), .GRP_IW(GRP_IW)
  ) u_timer (
    .clk(clk), .rst(rst), .load(take), .advance(slot_en && sending),
    .slot_idx(slot_idx), .grp_idx(grp_idx),
    .chip_last(chip_last), .word_last(word_last)
  );

  ppm_word_reg #(
    .DATA_W(DATA_W), .SYM_W(SYM_W), .GROUPS(GROUPS), .GRP_IW(GRP_IW)
  ) u_word (
    .clk(clk), .rst(rst), .load(take), .din(in_data),
    .grp_idx(grp_idx), .symbol(symbol)
  );

  ppm_slot_decode #(
    .SYM_W(SYM_W), .SLOTS(SLOTS), .SLOT_IW(SLOT_IW)
  ) u_dec (
    .active(sending), .symbol(symbol), .slot_idx(slot_idx), .pulse(ppm_out)
  );

  // Pulses already shown in the current chip (checking only).
  logic [SLOT_IW:0] chip_hits;
  always_ff @(posedge clk) begin
    if (rst || take) chip_hits <= '0;
    else if (slot_en && sending)
      chip_hits <= chip_last ? '0 : chip_hits + (SLOT_IW+1)'(ppm_out);
  end

  // R2: the closing slot of a chip sees exactly one pulse in total
  a_r2_one_pulse_per_chip: assert property (@(posedge clk) disable iff (rst)
    (slot_en && sending && chip_last) |-> ((chip_hits + (SLOT_IW+1)'(ppm_out)) == 1));

  // R4: a taken byte starts at slot one of chip one
  a_r4_start_aligned: assert property (@(posedge clk) disable iff (rst)
    take |=> (sending && slot_idx == '0 && grp_idx == '0));

  // R6: idle line is low
  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !sending |-> !ppm_out);

  // R1: line steady between enables
  a_r1_line_steady: assert property (@(posedge clk) disable iff (rst)
    (!slot_en && !$past(rst)) |=> $stable(ppm_out));

  // R7: reset leaves the line idle and low
  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> (!sending && !ppm_out));

endmodule

// File: tb/ppm_modulator_test.sv
module ppm_modulator_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       ppm_out;

  int checks = 0;
  int errors = 0;

  ppm_modulator uut (
    .clk(clk), .rst(rst), .slot_en(slot_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .ppm_out(ppm_out)
  );

  always #5 clk = ~clk;

  // Slot log: one entry per enabled edge.
  logic line_log [0:4095];
  int   log_n = 0;
  int   en_div = 1;
  int   stall_err = 0;
  int   starts [0:15];

  initial begin
    int  cnt = 0;
    bit  fired = 0;
    bit  rst_seen = 1;
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (fired) begin
        if (log_n < 4096) line_log[log_n] = ppm_out;
        log_n++;
      end else if (!rst_seen && ppm_out !== prev) begin
        stall_err++;
      end
      prev = ppm_out;
      rst_seen = rst;
      cnt++;
      slot_en = ((cnt % en_div) == 0);
      fired = slot_en;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_log(input int target);
    while (log_n < target) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] bs [0:15], input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      in_valid = 1'b1;
      in_data  = bs[i];
      while (!in_ready) begin
        @(negedge clk); #1;
      end
      starts[i] = log_n;
      @(posedge clk);
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Mismatching slots of one byte against the slot rule.
  function automatic int byte_errs(input int st, input logic [7:0] b);
    int bad = 0;
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 4; s++)
        if (line_log[st + g*4 + s] !== (s == int'(b[2*g +: 2]))) bad++;
    return bad;
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(ppm_out === 1'b0, "R7", "line low in reset", ppm_out, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk(ppm_out === 1'b0, "R6", "idle line after reset", ppm_out, 0);
    chk(in_ready === slot_en, "R5", "ready follows enable when idle", in_ready, slot_en);
  endtask

  task automatic t_example;
    logic [7:0] bs [0:15];
    int pos [4];
    int hits;
    bs[0] = 8'b1011_0001;
    en_div = 1;
    send(bs, 1);
    wait_log(starts[0] + 16);
    for (int g = 0; g < 4; g++) begin
      pos[g] = 0;
      for (int s = 0; s < 4; s++)
        if (line_log[starts[0] + g*4 + s] === 1'b1) pos[g] = s + 1;
    end
    chk(pos[0] == 2 && pos[1] == 1 && pos[2] == 4 && pos[3] == 3, "R8",
        "pulse slots 2,1,4,3 packed", pos[0]*1000 + pos[1]*100 + pos[2]*10 + pos[3], 2143);
    hits = 0;
    for (int k = 0; k < 16; k++) hits += int'(line_log[starts[0] + k]);
    chk(hits == 4, "R2", "one pulse per chip", hits, 4);
  endtask

  task automatic t_stream(input int div);
    logic [7:0] bs [0:15];
    int bad;
    bs[0] = 8'h00; bs[1] = 8'hFF; bs[2] = 8'hE4; bs[3] = 8'h1B; bs[4] = 8'h5A;
    en_div = div;
    send(bs, 5);
    wait_log(starts[4] + 20);
    for (int i = 1; i < 5; i++)
      chk(starts[i] - starts[i-1] == 16, "R4", "byte spacing in slots",
          starts[i] - starts[i-1], 16);
    bad = 0;
    for (int i = 0; i < 5; i++) bad += byte_errs(starts[i], bs[i]);
    chk(bad == 0, "R3", "group order over stream", bad, 0);
    bad = byte_errs(starts[2], 8'hE4);
    chk(bad == 0, "R2", "slot values 0..3 in one byte", bad, 0);
    bad = 0;
    for (int k = 0; k < 4; k++) bad += int'(line_log[starts[4] + 16 + k]);
    chk(bad == 0, "R6", "line low after last byte", bad, 0);
  endtask

  task automatic t_idle_gap;
    logic [7:0] bs [0:15];
    int first, bad;
    en_div = 3;
    bs[0] = 8'h6C;
    send(bs, 1);
    first = starts[0];
    wait_log(first + 16 + 9);
    bad = 0;
    for (int k = 16; k < 25; k++) bad += int'(line_log[first + k]);
    chk(bad == 0, "R6", "gap slots low", bad, 0);
    bs[0] = 8'h93;
    send(bs, 1);
    wait_log(starts[0] + 16);
    bad = byte_errs(starts[0], 8'h93);
    chk(bad == 0, "R6", "byte after gap starts at slot one", bad, 0);
  endtask

  task automatic t_ready_blocked;
    logic [7:0] bs [0:15];
    int early = 0;
    en_div = 1;
    bs[0] = 8'hA5;
    send(bs, 1);
    @(negedge clk); #1;
    in_valid = 1'b1;
    in_data  = 8'h3C;
    for (int k = 0; k < 8; k++) begin
      if (in_ready) early++;
      @(negedge clk); #1;
    end
    chk(early == 0, "R5", "ready low inside a byte", early, 0);
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    starts[1] = log_n;
    @(posedge clk);
    @(negedge clk); #1;
    in_valid = 1'b0;
    wait_log(starts[1] + 16);
    chk(starts[1] - starts[0] == 16, "R5", "held byte taken at boundary",
        starts[1] - starts[0], 16);
    chk(byte_errs(starts[0], 8'hA5) == 0 && byte_errs(starts[1], 8'h3C) == 0, "R5",
        "offered byte does not disturb line", byte_errs(starts[0], 8'hA5), 0);
  endtask

  task automatic t_stall;
    logic [7:0] bs [0:15];
    stall_err = 0;
    en_div = 5;
    bs[0] = 8'hC3; bs[1] = 8'h27;
    send(bs, 2);
    wait_log(starts[1] + 16);
    chk(stall_err == 0, "R1", "line changed without enable", stall_err, 0);
    chk(byte_errs(starts[1], 8'h27) == 0, "R1", "slow enable pattern",
        byte_errs(starts[1], 8'h27), 0);
  endtask

  task automatic t_reset_mid;
    logic [7:0] bs [0:15];
    int hi = 0;
    en_div = 1;
    bs[0] = 8'hFF;
    send(bs, 1);
    wait_log(starts[0] + 14);
    @(negedge clk); #1;
    rst = 1'b1;
    @(negedge clk); #1;
    rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      hi += int'(ppm_out);
      @(negedge clk); #1;
    end
    chk(hi == 0, "R7", "byte dropped by reset", hi, 0);
    bs[0] = 8'h1E;
    send(bs, 1);
    wait_log(starts[0] + 16);
    chk(byte_errs(starts[0], 8'h1E) == 0, "R7", "byte after reset whole",
        byte_errs(starts[0], 8'h1E), 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_example();
    t_stream(1);
    t_stream(3);
    t_idle_gap();
    t_ready_blocked();
    t_stall();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule